// File: doc/BRIEF.md
# Reset-Control and Reset-Status Register Block

This block sits on a 16-bit peripheral bus and holds two registers of a microcontroller's system-integration logic. The control register at address 0 carries a debug-clock enable, a software-reset trigger and two 2-bit fields that govern entry into the stop and wait low-power modes. Each of the two fields can freeze itself until the next device reset. The block turns the fields and the core's stop and wait requests into mode-entry signals. It also issues a one-cycle reset request when software asks for one.

The status register at address 1 keeps a sticky record of why the device was reset: power-on, external pin, watchdog or software. Power-on reset is an asynchronous input. It clears the record and leaves only the power-on flag set. Any other device reset is a synchronous `sysRst` level, and it only adds the cause flags present while it is held. Software removes flags by writing ones to them.

Top module: `rcs_regs`

## Requirements
- R1: While `porRst` or `sysRst` is active, the control register returns to 0x0000: debug enable 0, stop field 00, wait field 00.
- R2: Control bit 5 is the debug enable, readable and writable. `dbgClkOn` is high when that bit is 1 or when `tapEn` is high.
- R3: Control bits 3:2 form the stop field. While its upper bit is 0 (values 00 or 01) a write replaces it. Once it holds 10 or 11, writes leave it unchanged until the next reset. Other control bits in the same write still take effect.
- R4: Control bits 1:0 form the wait field. It follows the same write and lock rules as the stop field.
- R5: `stopAllowed` is high only when the stop field is 00, and `stopEnter` equals `stopReq` AND `stopAllowed`. `waitAllowed` and `waitEnter` behave the same way for the wait field and `waitReq`.
- R6: Writing 1 to control bit 4 drives `swRstReq` high for exactly the one cycle that follows the write edge. Bit 4 always reads 0.
- R7: Control bits 15:6 read as 0. Status bits 15:6 and 1:0 read as 0, and writes to them have no effect.
- R8: Power-on reset sets the status register to 0x0004: bit 2 is the power-on flag and every other flag is clear. No other event sets bit 2.
- R9: On each clock edge with `sysRst` high, status bit 5 is OR-ed with `swCause`, bit 4 with `wdogCause` and bit 3 with `extCause`. Flags already set are kept.
- R10: A status write clears every flag among bits 5:2 whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R11: A register is written only on a clock edge where `sel` and `wr` are both high and `sysRst` is low. `addr` 0 selects control and `addr` 1 selects status. `rdata` shows the selected register at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porRst | input | 1 | Power-on reset, asynchronous, active high |
| sysRst | input | 1 | Any other device reset, synchronous level, active high |
| extCause | input | 1 | External-pin reset cause, sampled while `sysRst` is high |
| wdogCause | input | 1 | Watchdog reset cause, sampled while `sysRst` is high |
| swCause | input | 1 | Software reset cause, sampled while `sysRst` is high |
| sel | input | 1 | Bus select |
| wr | input | 1 | Bus write strobe |
| addr | input | AddrW | Register address |
| wdata | input | DataW | Write data |
| rdata | output | DataW | Read data of the addressed register |
| tapEn | input | 1 | Core test access port enabled |
| stopReq | input | 1 | Core executes a stop instruction |
| waitReq | input | 1 | Core executes a wait instruction |
| dbgClkOn | output | 1 | Debug clock enable to the core |
| swRstReq | output | 1 | One-cycle software reset request |
| stopAllowed | output | 1 | Stop field is 00 |
| waitAllowed | output | 1 | Wait field is 00 |
| stopEnter | output | 1 | Enter stop mode |
| waitEnter | output | 1 | Enter wait mode |

## Verification
A register write lands on the rising edge where `sel` and `wr` are sampled high. Because read data and the mode and debug outputs are combinational from the registers, each of these results is valid during the low phase right after that edge. `swRstReq` rises on the write edge and falls on the following edge. The bench therefore drives inputs on falling edges and samples it on the next two falling edges, expecting high and then low. A `sysRst` pulse held across one rising edge changes the status and control registers on that edge, and the bench reads them on the following falling edge.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DBG_BIT  = 5;
  localparam int SWR_BIT  = 4;
  localparam int STOP_LO  = 2;
  localparam int WAIT_LO  = 0;
  localparam int FLD_W    = 2;
  localparam int NUM_FLD  = 2;
  localparam int STAT_LO  = 2;   // status flags occupy bits 5:2
  localparam int STAT_W   = 4;   // {sw, wdog, ext, por}
  localparam logic [STAT_W-1:0] STAT_POR_ONLY = 4'b0001;

  typedef struct packed {
    logic ctrlWe;   // write control register this edge
    logic statWe;   // write status register this edge
    logic hold;     // non-power-on reset active
    logic rdStat;   // read mux selects status
  } strobe_t;
endpackage

// File: rtl/rcs_mode_field.sv
module rcs_mode_field
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             porRst,
  input  logic             clr,
  input  logic             we,
  input  logic [FLD_W-1:0] din,
  output logic [FLD_W-1:0] fld,
  output logic             allowed
);
  logic locked;
  assign locked  = fld[FLD_W-1];
  assign allowed = (fld == '0);

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                fld <= '0;
    else if (clr)              fld <= '0;
    else if (we && !locked)    fld <= din;
  end

  // R3 / R4: a locked field keeps its value until a reset
  a_r3_r4_lock_hold: assert property (@(posedge clk) disable iff (porRst)
    (fld[FLD_W-1] && !clr) |=> (fld == $past(fld)));

  // R1: clear during system reset
  a_r1_clear: assert property (@(posedge clk) disable iff (porRst)
    clr |=> (fld == '0));
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int AddrW    = 1,
  parameter int CtrlAddr = 0,
  parameter int StatAddr = 1
)(
  input  logic             clk,
  input  logic             porRst,
  input  logic             sysRst,
  input  logic             sel,
  input  logic             wr,
  input  logic [AddrW-1:0] addr,
  input  logic             swBit,
  output strobe_t          strb,
  output logic             swRstReq
);
  localparam logic [AddrW-1:0] CtrlA = AddrW'(CtrlAddr);
  localparam logic [AddrW-1:0] StatA = AddrW'(StatAddr);

  logic busWe;
  assign busWe       = sel && wr && !sysRst;
  assign strb.ctrlWe = busWe && (addr == CtrlA);
  assign strb.statWe = busWe && (addr == StatA);
  assign strb.hold   = sysRst;
  assign strb.rdStat = (addr == StatA);

  logic swReqQ;
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) swReqQ <= 1'b0;
    else        swReqQ <= strb.ctrlWe && swBit;
  end
  assign swRstReq = swReqQ;

  // R6: a request only follows a bus write of the previous cycle
  a_r6_req_after_write: assert property (@(posedge clk) disable iff (porRst)
    $rose(swReqQ) |-> $past(sel && wr && !sysRst));

  // R11: never both registers in one write
  a_r11_one_target: assert property (@(posedge clk) disable iff (porRst)
    $onehot0({strb.ctrlWe, strb.statWe}));
endmodule

// File: rtl/rcs_dp.sv
module rcs_dp
  import rcs_pkg::*;
#(
  parameter int DataW = 16
)(
  input  logic             clk,
  input  logic             porRst,
  input  strobe_t          strb,
  input  logic [DataW-1:0] wdata,
  input  logic             extCause,
  input  logic             wdogCause,
  input  logic             swCause,
  input  logic             tapEn,
  input  logic             stopReq,
  input  logic             waitReq,
  output logic [DataW-1:0] rdata,
  output logic             dbgClkOn,
  output logic             stopAllowed,
  output logic             waitAllowed,
  output logic             stopEnter,
  output logic             waitEnter
);
  logic [FLD_W-1:0] modeFld [NUM_FLD];
  logic [NUM_FLD-1:0] modeOk;
  logic dbgQ;
  logic [STAT_W-1:0] statQ;

  // index 0 = stop field, index 1 = wait field
  for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld
    localparam int Lo = (gi == 0) ? STOP_LO : WAIT_LO;
    rcs_mode_field u_fld (
      .clk     (clk),
      .porRst  (porRst),
      .clr     (strb.hold),
      .we      (strb.ctrlWe),
      .din     (wdata[Lo +: FLD_W]),
      .fld     (modeFld[gi]),
      .allowed (modeOk[gi])
    );
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)           dbgQ <= 1'b0;
    else if (strb.hold)   dbgQ <= 1'b0;
    else if (strb.ctrlWe) dbgQ <= wdata[DBG_BIT];
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)           statQ <= STAT_POR_ONLY;
    else if (strb.hold)   statQ <= statQ | {swCause, wdogCause, extCause, 1'b0};
    else if (strb.statWe) statQ <= statQ & ~wdata[STAT_LO +: STAT_W];
  end

  assign dbgClkOn    = dbgQ || tapEn;
  assign stopAllowed = modeOk[0];
  assign waitAllowed = modeOk[1];
  assign stopEnter   = stopReq && modeOk[0];
  assign waitEnter   = waitReq && modeOk[1];

  always_comb begin
    rdata = '0;
    if (strb.rdStat) begin
      rdata[STAT_LO +: STAT_W] = statQ;
    end else begin
      rdata[DBG_BIT]            = dbgQ;
      rdata[STOP_LO +: FLD_W]   = modeFld[0];
      rdata[WAIT_LO +: FLD_W]   = modeFld[1];
    end
  end

  logic unusedBits;
  assign unusedBits = ^{wdata[DataW-1:STAT_LO+STAT_W], wdata[SWR_BIT]};

  // R9: a system reset never clears a flag
  a_r9_sticky: assert property (@(posedge clk) disable iff (porRst)
    strb.hold |=> ((statQ & $past(statQ)) == $past(statQ)));

  // R10: status is stable without reset or write
  a_r10_stable: assert property (@(posedge clk) disable iff (porRst)
    (!strb.hold && !strb.statWe) |=> (statQ == $past(statQ)));

  // R8: only power-on sets the power-on flag
  a_r8_por_only: assert property (@(posedge clk) disable iff (porRst)
    !statQ[0] |=> !statQ[0]);
endmodule

// File: rtl/rcs_regs.sv
module rcs_regs
  import rcs_pkg::*;
#(
  parameter int DataW = 16,
  parameter int AddrW = 1
)(
  input  logic             clk,
  input  logic             porRst,
  input  logic             sysRst,
  input  logic             extCause,
  input  logic             wdogCause,
  input  logic             swCause,
  input  logic             sel,
  input  logic             wr,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wdata,
  output logic [DataW-1:0] rdata,
  input  logic             tapEn,
  input  logic             stopReq,
  input  logic             waitReq,
  output logic             dbgClkOn,
  output logic             swRstReq,
  output logic             stopAllowed,
  output logic             waitAllowed,
  output logic             stopEnter,
  output logic             waitEnter
);
  strobe_t strb;

  rcs_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk      (clk),
    .porRst   (porRst),
    .sysRst   (sysRst),
    .sel      (sel),
    .wr       (wr),
    .addr     (addr),
    .swBit    (wdata[SWR_BIT]),
    .strb     (strb),
    .swRstReq (swRstReq)
  );

  rcs_dp #(.DataW(DataW)) u_dp (
    .clk         (clk),
    .porRst      (porRst),
    .strb        (strb),
    .wdata       (wdata),
    .extCause    (extCause),
    .wdogCause   (wdogCause),
    .swCause     (swCause),
    .tapEn       (tapEn),
    .stopReq     (stopReq),
    .waitReq     (waitReq),
    .rdata       (rdata),
    .dbgClkOn    (dbgClkOn),
    .stopAllowed (stopAllowed),
    .waitAllowed (waitAllowed),
    .stopEnter   (stopEnter),
    .waitEnter   (waitEnter)
  );
endmodule

// File: tb/tb_rcs_regs.sv
module tb_rcs_regs;
  logic clk = 1'b0;
  logic porRst = 1'b1, sysRst = 1'b0;
  logic extCause = 0, wdogCause = 0, swCause = 0;
  logic sel = 0, wr = 0;
  logic [0:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tapEn = 0, stopReq = 0, waitReq = 0;
  logic dbgClkOn, swRstReq, stopAllowed, waitAllowed, stopEnter, waitEnter;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rcs_regs dut (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic busWrite(logic a, logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic busRead(logic a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulseSys(logic e, logic w, logic s);
    @(negedge clk); sysRst = 1; extCause = e; wdogCause = w; swCause = s;
    @(negedge clk); sysRst = 0; extCause = 0; wdogCause = 0; swCause = 0;
  endtask

  task automatic testPor();
    logic [15:0] v;
    busRead(0, v); chk("R1 ctrl after por", v, 16'h0000);
    busRead(1, v); chk("R8 status after por", v, 16'h0004);
    chk("R5 stopAllowed reset", {15'b0, stopAllowed}, 16'h1);
    chk("R5 waitAllowed reset", {15'b0, waitAllowed}, 16'h1);
    chk("R6 no req at reset", {15'b0, swRstReq}, 16'h0);
  endtask

  task automatic testDbg();
    logic [15:0] v;
    busWrite(0, 16'h0020); busRead(0, v); chk("R2 dbg readback", v, 16'h0020);
    chk("R2 dbgClkOn bit", {15'b0, dbgClkOn}, 16'h1);
    busWrite(0, 16'h0000); #1 chk("R2 dbgClkOn off", {15'b0, dbgClkOn}, 16'h0);
    tapEn = 1; #1 chk("R2 dbgClkOn via tap", {15'b0, dbgClkOn}, 16'h1);
    tapEn = 0;
  endtask

  task automatic testSwReset();
    logic [15:0] v;
    @(negedge clk); sel = 1; wr = 1; addr = 0; wdata = 16'h0010;
    @(negedge clk); sel = 0; wr = 0; wdata = '0;
    chk("R6 pulse high", {15'b0, swRstReq}, 16'h1);
    @(negedge clk); chk("R6 pulse low", {15'b0, swRstReq}, 16'h0);
    busRead(0, v); chk("R6 bit reads 0", v, 16'h0000);
  endtask

  task automatic testReserved();
    logic [15:0] v;
    busWrite(0, 16'hFFC0); busRead(0, v); chk("R7 ctrl reserved", v, 16'h0000);
    busWrite(1, 16'hFFC3); busRead(1, v); chk("R7 status reserved", v, 16'h0004);
  endtask

  task automatic testModes();
    busWrite(0, 16'h0004); stopReq = 1; #1;
    chk("R5 stop 01 not allowed", {15'b0, stopAllowed}, 16'h0);
    chk("R5 stop 01 no entry", {15'b0, stopEnter}, 16'h0);
    busWrite(0, 16'h0000); #1 chk("R3 unlocked rewrite, R5 enter", {15'b0, stopEnter}, 16'h1);
    stopReq = 0; waitReq = 1;
    busWrite(0, 16'h0001); #1 chk("R5 wait 01 no entry", {15'b0, waitEnter}, 16'h0);
    busWrite(0, 16'h0000); #1 chk("R5 wait enter", {15'b0, waitEnter}, 16'h1);
    waitReq = 0;
  endtask

  task automatic testLock();
    logic [15:0] v;
    busWrite(0, 16'h0008); busRead(0, v); chk("R3 stop lock set", v, 16'h0008);
    busWrite(0, 16'h0000); busRead(0, v); chk("R3 locked write ignored", v, 16'h0008);
    chk("R3 stop still barred", {15'b0, stopAllowed}, 16'h0);
    busWrite(0, 16'h0003); busRead(0, v); chk("R4 wait lock 11", v, 16'h000B);
    busWrite(0, 16'h0021); busRead(0, v); chk("R4 locked, dbg writes", v, 16'h002B);
    pulseSys(1, 0, 0);
    busRead(0, v); chk("R1 sysRst clears ctrl", v, 16'h0000);
    busRead(1, v); chk("R9 ext flag added", v, 16'h000C);
  endtask

  task automatic testSticky();
    logic [15:0] v;
    pulseSys(0, 1, 0); busRead(1, v); chk("R9 wdog accumulates", v, 16'h001C);
    pulseSys(0, 0, 1); busRead(1, v); chk("R9 sw accumulates", v, 16'h003C);
  endtask

  task automatic testW1c();
    logic [15:0] v;
    busWrite(1, 16'h0020); busRead(1, v); chk("R10 clear sw", v, 16'h001C);
    busWrite(1, 16'h0000); busRead(1, v); chk("R10 zero no effect", v, 16'h001C);
    busWrite(1, 16'h001C); busRead(1, v); chk("R10 clear rest", v, 16'h0000);
    pulseSys(0, 0, 1); busRead(1, v); chk("R9 sw after clear", v, 16'h0020);
  endtask

  task automatic testGating();
    logic [15:0] v;
    @(negedge clk); sysRst = 1; sel = 1; wr = 1; addr = 0; wdata = 16'h0020;
    @(negedge clk); sysRst = 0; sel = 0; wr = 0; wdata = '0;
    busRead(0, v); chk("R11 write in reset ignored", v, 16'h0000);
    @(negedge clk); sel = 0; wr = 1; addr = 0; wdata = 16'h0020;
    @(negedge clk); wr = 0; wdata = '0;
    busRead(0, v); chk("R11 no sel ignored", v, 16'h0000);
    @(negedge clk); sel = 1; wr = 0; addr = 1; wdata = 16'h0020;
    @(negedge clk); sel = 0; wdata = '0;
    busRead(1, v); chk("R11 read only no clear", v, 16'h0020);
  endtask

  task automatic testPorAgain();
    logic [15:0] v;
    busWrite(0, 16'h0008);
    @(negedge clk); porRst = 1; @(negedge clk); porRst = 0;
    busRead(1, v); chk("R8 por restores status", v, 16'h0004);
    busRead(0, v); chk("R1 por clears locked ctrl", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRst = 0;
    testPor();
    testDbg();
    testSwReset();
    testReserved();
    testModes();
    testLock();
    testSticky();
    testW1c();
    testGating();
    testPorAgain();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired got 0x0000 expected 0x0001");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule